// File: doc/BRIEF.md
# DMA Channel Interrupt Status Logic

This block keeps the status flags of one DMA channel whose transfers are described by a linked chain of descriptors, and it drives that channel's interrupt line. A pulse reports each descriptor that finishes, together with its remaining byte count and whether the descriptor points to a successor. Separate pulses report bus faults: master abort, target abort, parity error and internal bus error. The descriptor's interrupt-enable bit decides whether a clean completion is reported. Faults are always reported.

Software reads a 7-bit status vector and clears flags by writing ones to them. The interrupt is a level. It stays high while any completion flag or fault flag is set. A fault seen at any point during a descriptor, including the cycle in which it finishes, stops that descriptor from being reported as complete. The channel keeps running after an end-of-transfer report, so a later fault can be flagged next to an end-of-transfer flag that is still pending.

Top module: `dma_irq_status`

## Requirements
- R1: Reset is synchronous and active low. During reset and just after it, every status bit is 0 and `irq` is 0.
- R2: A `chan_start` pulse sets status bit 0 (active). A software write of 1 to bit 0 has no effect on it.
- R3: A finish pulse with byte count 0, a non-null successor, interrupt-enable 1 and no fault in the descriptor sets bit 1 (end of transfer). The active bit stays 1.
- R4: A finish pulse with byte count 0 and a null successor clears the active bit in every case. If interrupt-enable is 1 and the descriptor saw no fault, it also sets bit 2 (end of chain).
- R5: When interrupt-enable is 0 at the finish pulse, neither bit 1 nor bit 2 is set.
- R6: The fault pulses set their own bits, whatever the interrupt-enable value: bit 3 master abort, bit 4 target abort, bit 5 parity, bit 6 internal bus error. Pulses arriving together set all their bits.
- R7: A fault since the last descriptor start, or a fault in the same cycle as the finish pulse, blocks both completion bits for that descriptor.
- R8: A `desc_start` pulse clears the fault memory of the descriptor and leaves the fault bits unchanged. A finish pulse with a nonzero byte count changes nothing.
- R9: `irq` is the OR of status bits 1 to 6. It stays high while any of them is set.
- R10: A write of 1 to any of bits 1 to 6 clears that bit, and a write of 0 leaves it unchanged. If a set event and a clearing write hit the same bit in the same cycle, the bit is set.
- R11: After an end-of-transfer report the channel continues, and a later internal bus error is flagged while bit 1 is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_start | input | 1 | Channel start pulse; also begins the first descriptor |
| desc_start | input | 1 | Pulse when a following descriptor begins |
| desc_done | input | 1 | Pulse when a descriptor finishes |
| desc_byte_cnt | input | CNT_W | Remaining byte count at finish |
| desc_next_null | input | 1 | 1 when the finished descriptor has no successor |
| desc_ie | input | 1 | Interrupt-enable bit of the current descriptor |
| err_master_abort | input | 1 | Master abort pulse |
| err_target_abort | input | 1 | Target abort pulse |
| err_parity | input | 1 | Bus parity error pulse |
| err_internal | input | 1 | Internal bus error pulse |
| csr_wr_en | input | 1 | Status write strobe |
| csr_wr_data | input | 7 | Write-one-to-clear mask for the status bits |
| status | output | 7 | Status flags, bit positions as in R2 to R6 |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that every event input is a single-cycle pulse sampled on the clock. They assume that `desc_ie`, `desc_byte_cnt` and `desc_next_null` are valid in the cycle of `desc_done`, and that `chan_start` does not arrive together with a finish pulse that ends the chain. The stimulus sets every input at the falling edge. It holds each pulse for exactly one cycle and never combines a start with a chain end. The only overlaps it creates on purpose are the ones the requirements define: a fault together with a finish pulse, a fault together with a descriptor start, and a fault together with a clearing write.

// File: rtl/dma_irq_pkg.sv
// Package dma_irq_pkg
// Shared widths, status bit positions and the completion classification
// used by the DMA channel interrupt status logic.
package dma_irq_pkg;
    localparam int ST_W    = 7;   // status vector width
    localparam int NUM_ERR = 4;   // fault sources
    localparam int B_ACT   = 0;   // active
    localparam int B_EOT   = 1;   // end of transfer
    localparam int B_EOC   = 2;   // end of chain
    localparam int B_ERR0  = 3;   // first fault bit (master, target, parity, internal)

    typedef enum logic [1:0] {
        CMP_NONE = 2'd0,
        CMP_EOT  = 2'd1,
        CMP_EOC  = 2'd2
    } cmp_kind_e;
endpackage

// File: rtl/dma_irq_err_track.sv
// Module dma_irq_err_track
// Keeps the per-descriptor fault memory. The memory is set by any fault pulse and
// cleared when a descriptor begins. If a fault and a begin land in the same
// cycle, the fault wins.
// Assumes: fault inputs are single-cycle pulses synchronous to clk.
module dma_irq_err_track #(
    parameter int NUM_ERR = dma_irq_pkg::NUM_ERR
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_ERR-1:0] err_vec,
    input  logic               desc_begin,
    output logic               err_any,
    output logic               err_seen
);
    // Any fault source active this cycle.
    always_comb err_any = |err_vec;

    // Fault memory register for the current descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_seen <= 1'b0;
        else if (err_any)
            err_seen <= 1'b1;
        else if (desc_begin)
            err_seen <= 1'b0;
    end

    a_r7_fault_remembered: assert property (@(posedge clk) disable iff (!rst_n)
        err_any |=> err_seen);
    a_r8_begin_forgets: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_begin && !err_any) |=> !err_seen);
endmodule

// File: rtl/dma_irq_completion.sv
// Module dma_irq_completion
// Sorts a finished descriptor as end of transfer or end of chain and gates
// the report with interrupt-enable and the fault state.
// Assumes: byte count, successor flag and enable are valid with desc_done.
module dma_irq_completion
    import dma_irq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             desc_done,
    input  logic [CNT_W-1:0] byte_cnt,
    input  logic             next_null,
    input  logic             ie,
    input  logic             err_seen,
    input  logic             err_now,
    output cmp_kind_e        kind,
    output logic             eot_set,
    output logic             eoc_set,
    output logic             chain_end
);
    logic clean;

    // Sort the finish event by byte count and successor.
    always_comb begin
        kind = CMP_NONE;
        if (desc_done && (byte_cnt == '0))
            kind = next_null ? CMP_EOC : CMP_EOT;
    end

    // Gate the report with enable and the fault state; the chain end always counts.
    always_comb begin
        clean     = !err_seen && !err_now;
        eot_set   = (kind == CMP_EOT) && ie && clean;
        eoc_set   = (kind == CMP_EOC) && ie && clean;
        chain_end = (kind == CMP_EOC);
    end
endmodule

// File: rtl/dma_irq_w1c_bit.sv
// Module dma_irq_w1c_bit
// One status flag that is set by an event and cleared by a write of one.
// If both happen in the same cycle, the set wins.
// Assumes: set and clr are synchronous to clk.
module dma_irq_w1c_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Flag register with set priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= 1'b0;
        else if (set)
            q <= 1'b1;
        else if (clr)
            q <= 1'b0;
    end

    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> q);
    a_r10_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !q);
endmodule

// File: rtl/dma_irq_status.sv
// Module dma_irq_status (top)
// Status flags and level interrupt of one descriptor-chained DMA channel.
// Bit 0 is active, bit 1 end of transfer, bit 2 end of chain, and bits 3 to 6
// are the faults. Bits 1 to 6 are write-one-to-clear and feed irq.
// Assumes: event inputs are single-cycle pulses, and chan_start never coincides
// with a finish pulse that ends the chain.
module dma_irq_status
    import dma_irq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chan_start,
    input  logic             desc_start,
    input  logic             desc_done,
    input  logic [CNT_W-1:0] desc_byte_cnt,
    input  logic             desc_next_null,
    input  logic             desc_ie,
    input  logic             err_master_abort,
    input  logic             err_target_abort,
    input  logic             err_parity,
    input  logic             err_internal,
    input  logic             csr_wr_en,
    input  logic [ST_W-1:0]  csr_wr_data,
    output logic [ST_W-1:0]  status,
    output logic             irq
);
    localparam int NUM_IRQ_BITS = ST_W - 1;

    logic [NUM_ERR-1:0] err_vec;
    logic               err_any;
    logic               err_seen;
    cmp_kind_e          kind;
    logic               eot_set;
    logic               eoc_set;
    logic               chain_end;
    logic               active_q;
    logic [ST_W-1:0]    set_vec;
    logic [ST_W-1:0]    clr_vec;
    logic [ST_W-1:0]    flag_q;

    // Collect the fault pulses in status bit order.
    always_comb err_vec = {err_internal, err_parity, err_target_abort, err_master_abort};

    dma_irq_err_track #(.NUM_ERR(NUM_ERR)) u_err (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_vec   (err_vec),
        .desc_begin(desc_start | chan_start),
        .err_any   (err_any),
        .err_seen  (err_seen)
    );

    dma_irq_completion #(.CNT_W(CNT_W)) u_cmp (
        .desc_done(desc_done),
        .byte_cnt (desc_byte_cnt),
        .next_null(desc_next_null),
        .ie       (desc_ie),
        .err_seen (err_seen),
        .err_now  (err_any),
        .kind     (kind),
        .eot_set  (eot_set),
        .eoc_set  (eoc_set),
        .chain_end(chain_end)
    );

    // Active flag: set by a channel start, cleared at the chain end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active_q <= 1'b0;
        else if (chan_start)
            active_q <= 1'b1;
        else if (chain_end)
            active_q <= 1'b0;
    end

    // Build the set and clear vectors for the write-one-to-clear bits.
    always_comb begin
        set_vec = '0;
        set_vec[B_EOT] = eot_set;
        set_vec[B_EOC] = eoc_set;
        set_vec[B_ERR0 +: NUM_ERR] = err_vec;
        clr_vec = csr_wr_en ? csr_wr_data : '0;
        clr_vec[B_ACT] = 1'b0;
    end

    for (genvar g = 1; g < ST_W; g++) begin : g_flag
        dma_irq_w1c_bit u_bit (
            .clk  (clk),
            .rst_n(rst_n),
            .set  (set_vec[g]),
            .clr  (clr_vec[g]),
            .q    (flag_q[g])
        );
    end

    // Assemble the outputs; the level interrupt comes from the registered flags.
    always_comb begin
        status        = flag_q;
        status[B_ACT] = active_q;
        irq           = |flag_q[ST_W-1:1];
    end

    // flag_q bit 0 is unused; tie it off.
    assign flag_q[0] = 1'b0;

    a_r2_start_sets_active: assert property (@(posedge clk) disable iff (!rst_n)
        chan_start |=> status[B_ACT]);
    a_r4_chain_end_idles: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_done && desc_byte_cnt == '0 && desc_next_null && !chan_start) |=> !status[B_ACT]);
    a_r5_no_eot_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!desc_ie && !status[B_EOT]) |=> !status[B_EOT]);
    a_r5_no_eoc_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!desc_ie && !status[B_EOC]) |=> !status[B_EOC]);
    a_r7_fault_blocks_eot: assert property (@(posedge clk) disable iff (!rst_n)
        (err_any && !status[B_EOT]) |=> !status[B_EOT]);
    a_r9_fault_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        err_any |=> irq);
    a_r8_partial_no_completion: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_done && desc_byte_cnt != '0 && !status[B_EOC]) |=> !status[B_EOC]);
endmodule

// File: tb/sim_dma_irq_status.sv
// Bench for dma_irq_status: a vector table walked by one loop, then directed
// tests for persistence of the level, a write of zeros, and reset in mid-run.
module sim_dma_irq_status;
    localparam int CNT_W = 16;
    localparam int NV    = 28;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             chan_start, desc_start, desc_done, desc_next_null, desc_ie;
    logic [CNT_W-1:0] desc_byte_cnt;
    logic             err_master_abort, err_target_abort, err_parity, err_internal;
    logic             csr_wr_en;
    logic [6:0]       csr_wr_data;
    logic [6:0]       status;
    logic             irq;
    int               total = 0;
    int               bad   = 0;
    bit               finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    dma_irq_status #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .chan_start(chan_start), .desc_start(desc_start),
        .desc_done(desc_done), .desc_byte_cnt(desc_byte_cnt), .desc_next_null(desc_next_null),
        .desc_ie(desc_ie), .err_master_abort(err_master_abort), .err_target_abort(err_target_abort),
        .err_parity(err_parity), .err_internal(err_internal), .csr_wr_en(csr_wr_en),
        .csr_wr_data(csr_wr_data), .status(status), .irq(irq)
    );

    // Row layout: start, dstart, done, cnt_zero, next_null, ie | err{int,par,tgt,mst}
    //             | wr_en | wr_data | expected status | expected irq
    localparam logic [25:0] VEC [NV] = '{
        26'b100000_0000_0_0000000_0000001_0,  //  0 R2 start
        26'b001101_0000_0_0000000_0000011_1,  //  1 R3 end of transfer
        26'b000000_0000_1_0000010_0000001_0,  //  2 R10 clear eot
        26'b010000_0000_0_0000000_0000001_0,  //  3 R8 next descriptor
        26'b001100_0000_0_0000000_0000001_0,  //  4 R5 ie=0
        26'b010000_1000_0_0000000_1000001_1,  //  5 R6 fault with begin
        26'b001101_0000_0_0000000_1000001_1,  //  6 R7 suppressed
        26'b000000_0000_1_1000000_0000001_0,  //  7 R10 clear
        26'b010000_0000_0_0000000_0000001_0,  //  8 R8
        26'b001101_0001_0_0000000_0001001_1,  //  9 R7 fault same cycle
        26'b000000_0000_1_0001000_0000001_0,  // 10 R10
        26'b010000_0000_0_0000000_0000001_0,  // 11 R8
        26'b001011_0000_0_0000000_0000001_0,  // 12 R8 nonzero count
        26'b001111_0000_0_0000000_0000100_1,  // 13 R4 end of chain
        26'b000000_0000_1_0000101_0000000_0,  // 14 R10 clear
        26'b100000_0000_0_0000000_0000001_0,  // 15 R2 restart
        26'b000000_0110_0_0000000_0110001_1,  // 16 R6 two faults
        26'b000000_0000_1_0100000_0010001_1,  // 17 R9 still high
        26'b000000_0010_1_0010000_0010001_1,  // 18 R10 set wins
        26'b000000_0000_1_0010000_0000001_0,  // 19 R10
        26'b010000_0000_0_0000000_0000001_0,  // 20 R8 memory cleared
        26'b001101_0000_0_0000000_0000011_1,  // 21 R8 clean completion
        26'b010000_0000_0_0000000_0000011_1,  // 22 R11 continues
        26'b000000_1000_0_0000000_1000011_1,  // 23 R11 fault with eot pending
        26'b000000_0000_1_0000001_1000011_1,  // 24 R2 write to active ignored
        26'b000000_0000_1_1000010_0000001_0,  // 25 R10
        26'b010000_0000_0_0000000_0000001_0,  // 26 R8
        26'b001110_0000_0_0000000_0000000_0   // 27 R4 chain end with ie=0
    };
    localparam int REQ [NV] = '{2,3,10,8,5,6,7,10,8,7,10,8,8,4,10,2,6,9,10,10,8,8,11,11,2,10,8,4};

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        chan_start = 0; desc_start = 0; desc_done = 0; desc_next_null = 0; desc_ie = 0;
        desc_byte_cnt = '0; err_master_abort = 0; err_target_abort = 0; err_parity = 0;
        err_internal = 0; csr_wr_en = 0; csr_wr_data = '0;
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0;
        idle_inputs();
        repeat (2) @(negedge clk);
        check(status == 7'd0 && irq == 1'b0, "R1 reset", {irq, status}, 8'd0);
        rst_n = 1;

        for (int i = 0; i < NV; i++) begin
            logic [25:0] v;
            v = VEC[i];
            chan_start     = v[25]; desc_start = v[24]; desc_done = v[23];
            desc_byte_cnt  = v[22] ? '0 : CNT_W'(i + 3);
            desc_next_null = v[21]; desc_ie = v[20];
            err_internal   = v[19]; err_parity = v[18]; err_target_abort = v[17];
            err_master_abort = v[16];
            csr_wr_en      = v[15]; csr_wr_data = v[14:8];
            @(negedge clk);
            check(status == v[7:1] && irq == v[0], $sformatf("R%0d row %0d", REQ[i], i),
                  {irq, status}, {v[0], v[7:1]});
        end

        // R9: level holds over idle cycles after a parity fault
        idle_inputs();
        err_parity = 1;
        @(negedge clk);
        idle_inputs();
        repeat (3) @(negedge clk);
        check(irq == 1'b1 && status[5] == 1'b1, "R9 level holds", {irq, status}, 8'b1010_0000);

        // R10: a write of zeros leaves the flags alone
        csr_wr_en = 1; csr_wr_data = 7'd0;
        @(negedge clk);
        idle_inputs();
        check(status[5] == 1'b1 && irq == 1'b1, "R10 zero write", {irq, status}, 8'b1010_0000);

        // R6: all four faults together, with ie=0
        err_master_abort = 1; err_target_abort = 1; err_parity = 1; err_internal = 1;
        @(negedge clk);
        idle_inputs();
        check(status[6:3] == 4'hF && irq, "R6 all faults", {irq, status}, 8'b1111_1000);

        // R1: reset in the middle of a run clears everything
        rst_n = 0;
        @(negedge clk);
        check(status == 7'd0 && irq == 1'b0, "R1 mid-run reset", {irq, status}, 8'd0);
        rst_n = 1;
        @(negedge clk);
        check(status == 7'd0 && irq == 1'b0, "R1 after reset", {irq, status}, 8'd0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule